// File: doc/BRIEF.md
# ADC Channel Control and Status Register Bank

This block keeps the configuration and alarm state of a four-channel analog-to-digital converter. Each channel owns a pair of byte registers in a small address window. The first byte sets the conversion resolution and the use of the channel pin as a simple open-drain output. The second byte sets the input range and the two alarm enables, holds the two alarm flags, and mirrors one device-wide power-on flag. A bus master reads and writes these bytes through a plain byte port. The protocol that carries those accesses lives elsewhere.

The conversion engine reports each finished conversion with a one-cycle strobe. The strobe carries the channel index, the result, and the low and high thresholds for that channel. On that strobe the block re-evaluates the channel's two alarm flags. It also combines the enabled alarms with the power-on flag into one flag that says whether the device answers a conditional search.

Top module: `adc_ctl_bank`

## Requirements
- R1: After reset, every first byte (addresses 08h, 0Ah, 0Ch, 0Eh) reads 08h and every second byte (09h, 0Bh, 0Dh, 0Fh) reads 8Ch. `res_bits` shows 8 for each channel, `out_en` and `driver_on` are 0, and `search_flag` is 1.
- R2: First-byte layout: bit 7 is the output enable, bit 6 is the output control, and bits 3:0 are the resolution code. Bits 5:4 always read 0, and writing 1 to them has no effect.
- R3: Second-byte layout: bit 7 is the power-on flag, bit 5 is the high alarm flag, bit 4 is the low alarm flag, bit 3 is the high alarm enable, bit 2 is the low alarm enable, and bit 0 is the input range select. Bits 6 and 1 always read 0.
- R4: `res_bits` shows 16 for a resolution code of 0000 and shows N for any other code N. `out_en`, `out_ctl` and `in_range_hi` follow the channel's register bits.
- R5: `driver_on` is 1 only when the output enable is 1 and the output control is 0. With the output enable at 0, the output control has no effect on `driver_on`.
- R6: On a conversion strobe, the high flag of the addressed channel becomes 1 if the result is strictly above the high threshold and 0 otherwise. The low flag becomes 1 if the result is strictly below the low threshold and 0 otherwise. A result equal to a threshold raises no flag.
- R7: A master write of 0 clears an alarm flag. A write of 1 leaves the flag unchanged.
- R8: When a master write to a second byte and a conversion strobe for the same channel fall in one cycle, the flags take the values the conversion gives. The other fields of that byte take the written values.
- R9: The power-on flag is a single bit shared by all channels and is read in bit 7 of every second byte. A write to any second byte sets it to the written bit 7, and the latest write wins. Writing 1 changes no other register.
- R10: `search_flag` is 1 when the power-on flag is 1, or when any channel has its high flag and high enable both set, or its low flag and low enable both set. A flag whose enable is 0 does not raise it.
- R11: An address outside 08h to 0Fh reads 00h, and a write to such an address changes no register.
- R12: A conversion strobe changes only the flags of the channel given by its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| conv_valid | input | 1 | One-cycle conversion-complete strobe |
| conv_ch | input | 2 | Channel index of the conversion |
| conv_result | input | 16 | Conversion result |
| conv_lo_thr | input | 16 | Low threshold of that channel |
| conv_hi_thr | input | 16 | High threshold of that channel |
| res_bits | output | 20 | Per-channel resolution in bits, 5 bits each, channel 0 lowest |
| out_en | output | 4 | Per-channel output enable |
| out_ctl | output | 4 | Per-channel output control |
| driver_on | output | 4 | Per-channel pull-low driver active |
| in_range_hi | output | 4 | Per-channel input range select |
| search_flag | output | 1 | Device participates in conditional search |

## Verification
A table writes bit patterns to both bytes of several channels, with every reserved bit and both flags set to 1, and reads each byte back. This separates masking by field from storage of a plain byte. Conversion results placed above, below and exactly on each threshold separate strict comparison from inclusive comparison. Running the same results with the alarm enables on and then off shows whether the search flag depends on the flag alone or on the enabled alarm. A write and a conversion in the same cycle, power-on writes through a channel other than the one read, and accesses just outside the window show whether priority, sharing and decoding hold.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
   // first byte field positions
   localparam int B0_OE  = 7;
   localparam int B0_OC  = 6;
   // second byte field positions
   localparam int B1_POR = 7;
   localparam int B1_AFH = 5;
   localparam int B1_AFL = 4;
   localparam int B1_AEH = 3;
   localparam int B1_AEL = 2;
   localparam int B1_IR  = 0;
   // reset field values
   localparam logic RST_OE  = 1'b0;
   localparam logic RST_OC  = 1'b0;
   localparam logic RST_POR = 1'b1;
   localparam logic RST_AE  = 1'b1;
   localparam logic RST_IR  = 1'b0;
   localparam int   RST_RES = 8;
endpackage

// File: rtl/adc_ctl_dec.sv
module adc_ctl_dec #(
   parameter int ADDR_W = 8,
   parameter int BASE   = 8,
   parameter int NUM_CH = 4,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [CH_W-1:0]   ch_idx,
   output logic              hi_byte
);
   localparam int LAST = BASE + 2*NUM_CH - 1;

   logic [ADDR_W-1:0] offset;
   logic              unused_off;

   assign offset     = addr - ADDR_W'(BASE);
   assign hit        = (32'(addr) >= BASE) && (32'(addr) <= LAST);
   assign ch_idx     = offset[CH_W:1];
   assign hi_byte    = offset[0];
   assign unused_off = ^offset;
endmodule

// File: rtl/adc_ctl_chan.sv
module adc_ctl_chan
   import adc_ctl_pkg::*;
#(
   parameter int RC_W   = 4,
   parameter int RST_RC = RST_RES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [7:0]      wdata,
   input  logic            upd,
   input  logic            hi_viol,
   input  logic            lo_viol,
   output logic [RC_W-1:0] rc,
   output logic            oe,
   output logic            oc,
   output logic            ir,
   output logic            aeh,
   output logic            ael,
   output logic            afh,
   output logic            afl
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rc  <= RC_W'(RST_RC);
         oe  <= RST_OE;
         oc  <= RST_OC;
      end else if (wr_lo) begin
         rc  <= wdata[RC_W-1:0];
         oe  <= wdata[B0_OE];
         oc  <= wdata[B0_OC];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir  <= RST_IR;
         aeh <= RST_AE;
         ael <= RST_AE;
      end else if (wr_hi) begin
         ir  <= wdata[B1_IR];
         aeh <= wdata[B1_AEH];
         ael <= wdata[B1_AEL];
      end
   end

   // conversion outcome outranks a master write; a write can only clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         afh <= 1'b0;
         afl <= 1'b0;
      end else if (upd) begin
         afh <= hi_viol;
         afl <= lo_viol;
      end else if (wr_hi) begin
         afh <= afh & wdata[B1_AFH];
         afl <= afl & wdata[B1_AFL];
      end
   end
endmodule

// File: rtl/adc_ctl_bank.sv
module adc_ctl_bank
   import adc_ctl_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int RES_W  = 16,
   parameter int ADDR_W = 8,
   parameter int BASE   = 8,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int RC_W   = $clog2(RES_W),
   localparam int BITS_W = $clog2(RES_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic                     conv_valid,
   input  logic [CH_W-1:0]          conv_ch,
   input  logic [RES_W-1:0]         conv_result,
   input  logic [RES_W-1:0]         conv_lo_thr,
   input  logic [RES_W-1:0]         conv_hi_thr,
   output logic [NUM_CH*BITS_W-1:0] res_bits,
   output logic [NUM_CH-1:0]        out_en,
   output logic [NUM_CH-1:0]        out_ctl,
   output logic [NUM_CH-1:0]        driver_on,
   output logic [NUM_CH-1:0]        in_range_hi,
   output logic                     search_flag
);
   // elaboration-time parameter checks
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (RES_W < 2 || RES_W > 16 || (1 << RC_W) != RES_W) begin : g_bad_res
      $error("RES_W must be a power of two from 2 to 16");
   end
   if (BASE % 2 != 0 || BASE + 2*NUM_CH > (1 << ADDR_W)) begin : g_bad_base
      $error("BASE must be even and the window must fit the address space");
   end

   logic              hit, hi_byte;
   logic [CH_W-1:0]   ch_idx;
   logic              por_q;
   logic              wr_any_hi;
   logic [NUM_CH-1:0] aeh_vec, ael_vec, afh_vec, afl_vec;
   logic [7:0]        byte_lo [NUM_CH];
   logic [7:0]        byte_hi [NUM_CH];

   adc_ctl_dec #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE),
      .NUM_CH (NUM_CH)
   ) u_dec (
      .addr    (addr),
      .hit     (hit),
      .ch_idx  (ch_idx),
      .hi_byte (hi_byte)
   );

   assign wr_any_hi = wr_en & hit & hi_byte;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic            sel, upd, hi_viol, lo_viol;
      logic [RC_W-1:0] rc;

      assign sel     = wr_en & hit & (ch_idx == CH_W'(i));
      assign upd     = conv_valid & (conv_ch == CH_W'(i));
      assign hi_viol = conv_result > conv_hi_thr;
      assign lo_viol = conv_result < conv_lo_thr;

      adc_ctl_chan #(
         .RC_W   (RC_W),
         .RST_RC (RST_RES)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (sel & ~hi_byte),
         .wr_hi   (sel & hi_byte),
         .wdata   (wdata),
         .upd     (upd),
         .hi_viol (hi_viol),
         .lo_viol (lo_viol),
         .rc      (rc),
         .oe      (out_en[i]),
         .oc      (out_ctl[i]),
         .ir      (in_range_hi[i]),
         .aeh     (aeh_vec[i]),
         .ael     (ael_vec[i]),
         .afh     (afh_vec[i]),
         .afl     (afl_vec[i])
      );

      assign res_bits[i*BITS_W +: BITS_W] =
         (rc == '0) ? BITS_W'(RES_W) : BITS_W'(rc);
      assign driver_on[i] = out_en[i] & ~out_ctl[i];

      always_comb begin
         byte_lo[i]           = '0;
         byte_lo[i][B0_OE]    = out_en[i];
         byte_lo[i][B0_OC]    = out_ctl[i];
         byte_lo[i][RC_W-1:0] = rc;
         byte_hi[i]           = '0;
         byte_hi[i][B1_POR]   = por_q;
         byte_hi[i][B1_AFH]   = afh_vec[i];
         byte_hi[i][B1_AFL]   = afl_vec[i];
         byte_hi[i][B1_AEH]   = aeh_vec[i];
         byte_hi[i][B1_AEL]   = ael_vec[i];
         byte_hi[i][B1_IR]    = in_range_hi[i];
      end
   end

   // device-wide power-on flag, latest write through any channel wins
   always_ff @(posedge clk) begin
      if (!rst_n)         por_q <= RST_POR;
      else if (wr_any_hi) por_q <= wdata[B1_POR];
   end

   assign search_flag = por_q | (|(afh_vec & aeh_vec)) | (|(afl_vec & ael_vec));

   always_comb begin
      rdata = '0;
      if (hit) rdata = hi_byte ? byte_hi[ch_idx] : byte_lo[ch_idx];
   end
endmodule

// File: rtl/adc_ctl_bank_chk.sv
module adc_ctl_bank_chk #(
   parameter int NUM_CH = 4,
   parameter int RES_W  = 16,
   parameter int ADDR_W = 8,
   parameter int BASE   = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              conv_valid,
   input logic [CH_W-1:0]   conv_ch,
   input logic [RES_W-1:0]  conv_result,
   input logic [RES_W-1:0]  conv_lo_thr,
   input logic [RES_W-1:0]  conv_hi_thr,
   input logic              search_flag,
   input logic              por_q,
   input logic [NUM_CH-1:0] afh_vec,
   input logic [NUM_CH-1:0] afl_vec
);
   logic in_win;
   assign in_win = (32'(addr) >= BASE) && (32'(addr) < BASE + 2*NUM_CH);

   AST_RSV_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && addr[0] == 1'b0) |-> (rdata[5:4] == 2'b00)); // R2

   AST_RSV_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && addr[0] == 1'b1) |-> (rdata[6] == 1'b0 && rdata[1] == 1'b0)); // R3

   AST_AFH_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && conv_result > conv_hi_thr) |=> afh_vec[$past(conv_ch)]); // R6

   AST_AFL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && conv_result < conv_lo_thr) |=> afl_vec[$past(conv_ch)]); // R6

   AST_FLAG_NO_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |=> ((afh_vec & ~$past(afh_vec)) == '0 && (afl_vec & ~$past(afl_vec)) == '0)); // R7

   AST_POR_LATEST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && addr[0]) |=> (por_q == $past(wdata[7]))); // R9

   AST_POR_MEANS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      por_q |-> search_flag); // R10

   AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (rdata == 8'h00)); // R11
endmodule

bind adc_ctl_bank adc_ctl_bank_chk #(
   .NUM_CH (NUM_CH),
   .RES_W  (RES_W),
   .ADDR_W (ADDR_W),
   .BASE   (BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .wdata       (wdata),
   .rdata       (rdata),
   .conv_valid  (conv_valid),
   .conv_ch     (conv_ch),
   .conv_result (conv_result),
   .conv_lo_thr (conv_lo_thr),
   .conv_hi_thr (conv_hi_thr),
   .search_flag (search_flag),
   .por_q       (por_q),
   .afh_vec     (afh_vec),
   .afl_vec     (afl_vec)
);

// File: tb/sim_adc_ctl_bank.sv
module sim_adc_ctl_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        conv_valid = 1'b0;
   logic [1:0]  conv_ch = '0;
   logic [15:0] conv_result = '0;
   logic [15:0] conv_lo_thr = '0;
   logic [15:0] conv_hi_thr = '0;
   logic [19:0] res_bits;
   logic [3:0]  out_en, out_ctl, driver_on, in_range_hi;
   logic        search_flag;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   adc_ctl_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .conv_valid(conv_valid), .conv_ch(conv_ch),
      .conv_result(conv_result), .conv_lo_thr(conv_lo_thr),
      .conv_hi_thr(conv_hi_thr), .res_bits(res_bits), .out_en(out_en),
      .out_ctl(out_ctl), .driver_on(driver_on), .in_range_hi(in_range_hi),
      .search_flag(search_flag)
   );

   // {address, write data, expected read-back}
   localparam logic [23:0] VEC [8] = '{
      {8'h08, 8'hFF, 8'hCF},   // R2 reserved 5:4 masked
      {8'h08, 8'h35, 8'h05},   // R2
      {8'h0A, 8'h80, 8'h80},   // R2
      {8'h09, 8'hFF, 8'h8D},   // R3 flags cannot be set by write
      {8'h0B, 8'h4E, 8'h0C},   // R3 bits 6 and 1 masked
      {8'h0F, 8'h01, 8'h01},   // R3
      {8'h0E, 8'h0F, 8'h0F},   // R2
      {8'h0C, 8'h3A, 8'h0A}    // R2
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
      addr = a;
      #1;
      check(req, 32'(rdata), 32'(exp));
   endtask

   task automatic conv(logic [1:0] ch, logic [15:0] res, logic [15:0] lo, logic [15:0] hi);
      @(negedge clk);
      conv_valid = 1'b1; conv_ch = ch; conv_result = res;
      conv_lo_thr = lo; conv_hi_thr = hi;
      @(negedge clk);
      conv_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();

      // table walk: write then read back
      for (int i = 0; i < 8; i++) begin
         wr(VEC[i][23:16], VEC[i][15:8]);
         rd("R2/R3 table", VEC[i][23:16], VEC[i][7:0]);
      end

      do_reset();

      // R1 reset state
      for (int a = 8; a < 16; a++)
         rd("R1 reset byte", 8'(a), (a % 2 == 0) ? 8'h08 : 8'h8C);
      check("R1 search", 32'(search_flag), 1);
      check("R1 res_bits", 32'(res_bits), {5'd8, 5'd8, 5'd8, 5'd8});
      check("R1 out_en", 32'(out_en), 0);
      check("R1 driver_on", 32'(driver_on), 0);

      // R4 resolution decode and outputs
      wr(8'h08, 8'h00);
      check("R4 code 0 -> 16", 32'(res_bits[4:0]), 16);
      wr(8'h08, 8'h0F);
      check("R4 code F -> 15", 32'(res_bits[4:0]), 15);
      wr(8'h0E, 8'h03);
      check("R4 ch3 code 3", 32'(res_bits[19:15]), 3);
      wr(8'h0D, 8'h01);
      check("R4 in_range_hi", 32'(in_range_hi), 32'h4);

      // R5 output driver
      wr(8'h08, 8'h40);
      check("R5 oc ignored when oe=0", 32'(driver_on), 0);
      check("R4 out_ctl", 32'(out_ctl), 1);
      wr(8'h08, 8'h80);
      check("R5 driver on", 32'(driver_on), 1);
      wr(8'h08, 8'hC0);
      check("R5 driver off", 32'(driver_on), 0);
      check("R4 out_en", 32'(out_en), 1);

      // R9 clear power-on via channel 2, seen by others; R10 no search
      wr(8'h0D, 8'h0C);
      rd("R9 por cleared ch0", 8'h09, 8'h0C);
      rd("R9 por cleared ch1", 8'h0B, 8'h0C);
      check("R10 idle search", 32'(search_flag), 0);

      // R6 threshold compare on channel 1
      conv(2'd1, 16'h9000, 16'h1000, 16'h8000);
      rd("R6 above high", 8'h0B, 8'h2C);
      check("R10 high alarm search", 32'(search_flag), 1);
      wr(8'h0B, 8'h3C);
      rd("R7 write 1 keeps", 8'h0B, 8'h2C);
      wr(8'h0B, 8'h0C);
      rd("R7 write 0 clears", 8'h0B, 8'h0C);
      check("R10 cleared search", 32'(search_flag), 0);
      conv(2'd1, 16'h0800, 16'h1000, 16'h8000);
      rd("R6 below low", 8'h0B, 8'h1C);
      conv(2'd1, 16'h8000, 16'h1000, 16'h8000);
      rd("R6 equal high no flag", 8'h0B, 8'h0C);
      conv(2'd1, 16'h0800, 16'h1000, 16'h8000);
      conv(2'd1, 16'h1000, 16'h1000, 16'h8000);
      rd("R6 equal low clears", 8'h0B, 8'h0C);

      // R8 same-cycle write and conversion
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h0B; wdata = 8'h0D;
      conv_valid = 1'b1; conv_ch = 2'd1; conv_result = 16'h9000;
      conv_lo_thr = 16'h1000; conv_hi_thr = 16'h8000;
      @(negedge clk);
      wr_en = 1'b0; conv_valid = 1'b0;
      rd("R8 conversion wins", 8'h0B, 8'h2D);

      // R10 enables gate the search flag
      wr(8'h0B, 8'h00);
      rd("R7 write clears with enables off", 8'h0B, 8'h00);
      conv(2'd1, 16'h9000, 16'h1000, 16'h8000);
      rd("R10 flag without enable", 8'h0B, 8'h20);
      check("R10 disabled alarm no search", 32'(search_flag), 0);
      wr(8'h0B, 8'h04);
      conv(2'd1, 16'h0800, 16'h1000, 16'h8000);
      rd("R10 low alarm enabled", 8'h0B, 8'h14);
      check("R10 low alarm search", 32'(search_flag), 1);

      // R12 other channels untouched
      rd("R12 ch0 flags", 8'h09, 8'h0C);
      rd("R12 ch2 flags", 8'h0D, 8'h0C);

      // R9 writing 1 sets flag without reset
      wr(8'h0F, 8'h8C);
      check("R9 por set search", 32'(search_flag), 1);
      rd("R9 por seen ch0", 8'h09, 8'h8C);
      rd("R9 no reset of byte0", 8'h08, 8'hC0);

      // R11 outside the window
      rd("R11 read 07", 8'h07, 8'h00);
      rd("R11 read 10", 8'h10, 8'h00);
      rd("R11 read FF", 8'hFF, 8'h00);
      wr(8'h10, 8'hFF);
      wr(8'h07, 8'h00);
      rd("R11 write ignored ch0", 8'h08, 8'hC0);
      rd("R11 write ignored ch3", 8'h0F, 8'h8C);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule